// File: doc/BRIEF.md
# Three-Port Latchable Datapath Multiplexer

This block moves 9-bit words (eight data bits plus one parity bit in bit 8) among three bidirectional ports named A, B and C. Each port is split into an input word, an output word and an output-enable flag that stands in for a tri-state pad. Every port owns a holding register that captures its input word on a clock edge while that port's load enable is high, and keeps its contents otherwise.

Each port has its own 2-bit route select that decides which held word it drives: held A, held B, held C, or a forced zero word. A port may select its own held word, which lets a system read back what it captured for self-check. A parity-invert control flips bit 8 of the word from C, but only when that word leaves through port A or port B. All load enables, output enables, selects and the invert control are independent inputs.

Top module: `dpmux_xbar`

## Requirements
- R1: While rst_ni is low, all three holding registers clear to zero, so any enabled port selecting A, B or C drives 9'h000 after reset.
- R2: A port's holding register takes that port's input word at a rising clk_i edge when its load enable is 1, and keeps its value at edges where the load enable is 0.
- R3: Route select encoding per port: 2'b00 drives held A, 2'b01 drives held B, 2'b10 drives held C, 2'b11 drives 9'h000; the output follows the select with no clock delay.
- R4: A port whose select names its own held word drives that word unchanged (readback).
- R5: Each port's enable flag output equals its output-enable input; while the flag is 0 the port's output word is 9'h000 and carries no meaning.
- R6: With pinv_i at 1, port A or port B selecting held C drives held C with bit 8 inverted and bits 7:0 unchanged; with pinv_i at 0 they drive held C unchanged.
- R7: pinv_i has no effect on any other path: port C selecting held C, and every port selecting held A, held B or the zero code.
- R8: Load enables act per port: loading one port's register leaves the other two registers, as seen through the outputs, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the holding registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 9 | Port A input word |
| b_i | input | 9 | Port B input word |
| c_i | input | 9 | Port C input word |
| ld_a_i | input | 1 | Load enable for held A |
| ld_b_i | input | 1 | Load enable for held B |
| ld_c_i | input | 1 | Load enable for held C |
| oe_a_i | input | 1 | Output enable for port A |
| oe_b_i | input | 1 | Output enable for port B |
| oe_c_i | input | 1 | Output enable for port C |
| sel_a_i | input | 2 | Route select for port A |
| sel_b_i | input | 2 | Route select for port B |
| sel_c_i | input | 2 | Route select for port C |
| pinv_i | input | 1 | Parity invert on the C-to-A and C-to-B paths |
| a_o | output | 9 | Port A output word |
| b_o | output | 9 | Port B output word |
| c_o | output | 9 | Port C output word |
| a_oe_o | output | 1 | Port A drive flag (0 means high impedance) |
| b_oe_o | output | 1 | Port B drive flag (0 means high impedance) |
| c_oe_o | output | 1 | Port C drive flag (0 means high impedance) |

## Verification
After every load step the bench walks all 64 select combinations of the three ports with the invert control at both values, so each source-to-destination pairing, the readback paths and the zero code are all seen with the same held words; words with distinct parity bits separate an inverted C path from an untouched one. Held words come from walking ones, alternating bit patterns, all ones and an arithmetic sequence, which tell apart swapped sources and stuck or crossed bits. Every load-enable combination is applied per step, so a register that loads when it should hold, or a load leaking to a neighbour, shows up in the next sweep. Output-enable patterns are swept separately and only the flag is judged on disabled ports.

// File: rtl/dpmux_pkg.sv
package dpmux_pkg;
  localparam int unsigned NPORT = 3;
  localparam int unsigned PORT_A = 0;
  localparam int unsigned PORT_B = 1;
  localparam int unsigned PORT_C = 2;

  typedef enum logic [1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_C    = 2'b10,
    SRC_ZERO = 2'b11
  } src_sel_e;
endpackage

// File: rtl/dpmux_hold.sv
module dpmux_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/dpmux_route.sv
module dpmux_route
  import dpmux_pkg::*;
#(
  parameter int unsigned W          = 9,
  parameter bit          INV_FROM_C = 1'b1
) (
  input  logic [W-1:0] hold_a_i,
  input  logic [W-1:0] hold_b_i,
  input  logic [W-1:0] hold_c_i,
  input  logic [1:0]   sel_i,
  input  logic         pinv_i,
  input  logic         oe_i,
  output logic [W-1:0] d_o,
  output logic         oe_o
);
  logic [W-1:0] c_path;
  logic [W-1:0] pick;

  // parity flip only on the C path into the other ports
  generate
    if (INV_FROM_C) begin : g_inv
      assign c_path = hold_c_i ^ {pinv_i, {(W-1){1'b0}}};
    end else begin : g_noinv
      logic unused_pinv;
      assign unused_pinv = pinv_i;
      assign c_path      = hold_c_i;
    end
  endgenerate

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SRC_A:   pick = hold_a_i;
      SRC_B:   pick = hold_b_i;
      SRC_C:   pick = c_path;
      default: pick = '0;
    endcase
  end

  assign oe_o = oe_i;
  assign d_o  = oe_i ? pick : '0;
endmodule

// File: rtl/dpmux_xbar.sv
module dpmux_xbar
  import dpmux_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned W     = DATA_W + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         ld_a_i,
  input  logic         ld_b_i,
  input  logic         ld_c_i,
  input  logic         oe_a_i,
  input  logic         oe_b_i,
  input  logic         oe_c_i,
  input  logic [1:0]   sel_a_i,
  input  logic [1:0]   sel_b_i,
  input  logic [1:0]   sel_c_i,
  input  logic         pinv_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic         a_oe_o,
  output logic         b_oe_o,
  output logic         c_oe_o
);
  logic [W-1:0] din  [NPORT];
  logic [W-1:0] hold [NPORT];
  logic [W-1:0] dout [NPORT];
  logic [1:0]   sel  [NPORT];
  logic         ld   [NPORT];
  logic         oe   [NPORT];
  logic         oeo  [NPORT];

  assign din[PORT_A] = a_i;
  assign din[PORT_B] = b_i;
  assign din[PORT_C] = c_i;
  assign ld[PORT_A]  = ld_a_i;
  assign ld[PORT_B]  = ld_b_i;
  assign ld[PORT_C]  = ld_c_i;
  assign oe[PORT_A]  = oe_a_i;
  assign oe[PORT_B]  = oe_b_i;
  assign oe[PORT_C]  = oe_c_i;
  assign sel[PORT_A] = sel_a_i;
  assign sel[PORT_B] = sel_b_i;
  assign sel[PORT_C] = sel_c_i;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      dpmux_hold #(.W(W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ld_i   (ld[p]),
        .d_i    (din[p]),
        .q_o    (hold[p])
      );

      dpmux_route #(.W(W), .INV_FROM_C(p != PORT_C)) u_route (
        .hold_a_i (hold[PORT_A]),
        .hold_b_i (hold[PORT_B]),
        .hold_c_i (hold[PORT_C]),
        .sel_i    (sel[p]),
        .pinv_i   (pinv_i),
        .oe_i     (oe[p]),
        .d_o      (dout[p]),
        .oe_o     (oeo[p])
      );
    end
  endgenerate

  assign a_o    = dout[PORT_A];
  assign b_o    = dout[PORT_B];
  assign c_o    = dout[PORT_C];
  assign a_oe_o = oeo[PORT_A];
  assign b_oe_o = oeo[PORT_B];
  assign c_oe_o = oeo[PORT_C];

  // named taps for the bound checker
  logic [W-1:0] hold_a_q, hold_b_q, hold_c_q;
  assign hold_a_q = hold[PORT_A];
  assign hold_b_q = hold[PORT_B];
  assign hold_c_q = hold[PORT_C];
endmodule

// File: rtl/dpmux_chk.sv
module dpmux_chk #(
  parameter int unsigned W = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic         ld_a_i,
  input logic         ld_b_i,
  input logic         oe_a_i,
  input logic         oe_c_i,
  input logic [1:0]   sel_a_i,
  input logic [1:0]   sel_c_i,
  input logic         pinv_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] c_o,
  input logic         b_oe_o,
  input logic         oe_b_i,
  input logic [W-1:0] hold_a_q,
  input logic [W-1:0] hold_b_q,
  input logic [W-1:0] hold_c_q
);
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a_i |=> hold_a_q == $past(a_i));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_a_i |=> $stable(hold_a_q));

  assert_indep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_a_i && !ld_b_i) |=> $stable(hold_b_q));

  assert_zero_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_i && sel_a_i == 2'b11) |-> a_o == '0);

  assert_oe_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_oe_o == oe_b_i);

  assert_pinv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_a_i && sel_a_i == 2'b10) |-> a_o == (hold_c_q ^ {pinv_i, {(W-1){1'b0}}}));

  assert_loop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_c_i && sel_c_i == 2'b10) |-> c_o == hold_c_q);
endmodule

bind dpmux_xbar dpmux_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .ld_a_i   (ld_a_i),
  .ld_b_i   (ld_b_i),
  .oe_a_i   (oe_a_i),
  .oe_c_i   (oe_c_i),
  .sel_a_i  (sel_a_i),
  .sel_c_i  (sel_c_i),
  .pinv_i   (pinv_i),
  .a_o      (a_o),
  .c_o      (c_o),
  .b_oe_o   (b_oe_o),
  .oe_b_i   (oe_b_i),
  .hold_a_q (hold_a_q),
  .hold_b_q (hold_b_q),
  .hold_c_q (hold_c_q)
);

// File: tb/sim_dpmux_xbar.sv
module sim_dpmux_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic ld_a = 0, ld_b = 0, ld_c = 0;
  logic oe_a = 0, oe_b = 0, oe_c = 0;
  logic [1:0] sel_a = 0, sel_b = 0, sel_c = 0;
  logic pinv = 0;
  logic [W-1:0] a_o, b_o, c_o;
  logic a_oe, b_oe, c_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [W-1:0] mdl [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpmux_xbar u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .ld_a_i(ld_a), .ld_b_i(ld_b), .ld_c_i(ld_c),
    .oe_a_i(oe_a), .oe_b_i(oe_b), .oe_c_i(oe_c),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c),
    .pinv_i(pinv),
    .a_o(a_o), .b_o(b_o), .c_o(c_o),
    .a_oe_o(a_oe), .b_oe_o(b_oe), .c_oe_o(c_oe)
  );

  function automatic logic [W-1:0] expect_word(int p, logic [1:0] s, logic pv);
    case (s)
      2'b00: return mdl[0];
      2'b01: return mdl[1];
      2'b10: return (pv && p != 2) ? (mdl[2] ^ 9'h100) : mdl[2];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int p, logic [1:0] s);
    if (s == 2'b11) return "R3";
    if (s == p[1:0]) return "R4";
    if (s == 2'b10) return "R6";
    return "R7";
  endfunction

  task automatic check_word(string tag, string nm, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
    end
  endtask

  task automatic check_flag(string tag, string nm, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b", tag, nm, act, exp);
    end
  endtask

  // full route sweep against the model; outputs are combinational
  task automatic sweep_routes(string ltag);
    oe_a = 1; oe_b = 1; oe_c = 1;
    for (int k = 0; k < 128; k++) begin
      sel_a = k[1:0]; sel_b = k[3:2]; sel_c = k[5:4]; pinv = k[6];
      #1;
      check_word(k == 0 ? ltag : tag_of(0, sel_a), "a_o", a_o, expect_word(0, sel_a, pinv));
      check_word(tag_of(1, sel_b), "b_o", b_o, expect_word(1, sel_b, pinv));
      check_word(tag_of(2, sel_c), "c_o", c_o, expect_word(2, sel_c, pinv));
    end
    // R5: enables sweep; disabled ports judged on flag only
    sel_a = 2'b10; sel_b = 2'b00; sel_c = 2'b01; pinv = 1;
    for (int e = 0; e < 8; e++) begin
      oe_a = e[0]; oe_b = e[1]; oe_c = e[2];
      #1;
      check_flag("R5", "a_oe", a_oe, e[0]);
      check_flag("R5", "b_oe", b_oe, e[1]);
      check_flag("R5", "c_oe", c_oe, e[2]);
      if (e[0]) check_word("R5", "a_o", a_o, expect_word(0, sel_a, pinv));
      if (e[1]) check_word("R5", "b_o", b_o, expect_word(1, sel_b, pinv));
      if (e[2]) check_word("R5", "c_o", c_o, expect_word(2, sel_c, pinv));
    end
  endtask

  task automatic load_step(logic [W-1:0] va, logic [W-1:0] vb, logic [W-1:0] vc, int lmask);
    @(negedge clk);
    a_i = va; b_i = vb; c_i = vc;
    ld_a = lmask[0]; ld_b = lmask[1]; ld_c = lmask[2];
    @(posedge clk);
    if (lmask[0]) mdl[0] = va;
    if (lmask[1]) mdl[1] = vb;
    if (lmask[2]) mdl[2] = vc;
    #1;
    ld_a = 0; ld_b = 0; ld_c = 0;
    // new input values must not reach held words without a load
    a_i = ~va; b_i = ~vb; c_i = ~vc;
  endtask

  function automatic logic [W-1:0] pattern(int i, int j);
    case (i % 5)
      0: return 9'(1) << ((i + j) % W);
      1: return (j[0]) ? 9'h155 : 9'h0AA;
      2: return 9'h1FF;
      3: return 9'((i * 37 + j * 101) % 512);
      default: return 9'((i * 71 + j * 13 + 256) % 512);
    endcase
  endfunction

  initial begin
    mdl[0] = '0; mdl[1] = '0; mdl[2] = '0;
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1;
    #1;
    sweep_routes("R1");
    for (int i = 0; i < 20; i++) begin
      for (int m = 0; m < 8; m++) begin
        load_step(pattern(i, 3 * m), pattern(i, 3 * m + 1), pattern(i, 3 * m + 2), m);
        // R2 load/hold and R8 per-port independence seen through the sweep
        sweep_routes(m == 0 ? "R2" : "R8");
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule